// File: doc/BRIEF.md
# UART FIFO Ready-Signal Generator

This block holds the transmit and receive byte queues of a 16550-style serial port. It also drives the two active-low ready strobes that a DMA engine watches to decide when to refill the transmit side or drain the receive side. The shifters, baud timing, register decode and the timeout counter are outside the block. The control byte arrives already decoded, and the receive timeout arrives as a single-cycle pulse.

There are two handshake behaviours. In the per-character behaviour, a ready strobe is active whenever a single transfer is possible. In the block-transfer behaviour, transmit-ready stays active until the queue is completely full. Receive-ready becomes active once the programmed threshold is reached or a timeout pulse arrives, and it then stays active until the queue is fully drained. A trigger-reached flag and both occupancy counts are brought out for the neighbouring interrupt logic.

Top module: `uart_fifo_dma_rdy`

## Requirements
- R1: Bits of `fifoCtrl` are used as follows. Bit 0 is queue enable, bit 3 is DMA select, and bits 7:6 are the receive threshold. The block-transfer behaviour is active only when both bit 0 and bit 3 are 1. Every other combination selects the per-character behaviour.
- R2: In per-character behaviour, `txRdyN` is 0 while `txCount` is 0. It is 1 in the cycle that follows the edge at which the first byte is written.
- R3: In per-character behaviour, `rxRdyN` is 0 while `rxCount` is at least 1, and it is 1 while `rxCount` is 0.
- R4: In block-transfer behaviour, `txRdyN` is 1 exactly when `txCount` equals 16, and it is 0 when fewer bytes are held.
- R5: In block-transfer behaviour, `rxRdyN` goes to 0 after an edge that leaves `rxCount` at or above the threshold. It also goes to 0 after an edge with `rxTimeout` high that leaves the queue non-empty. It then stays 0 until the edge that empties the queue, and it is 1 in the cycle after that edge.
- R6: The threshold code in bits 7:6 maps 00 to 1, 01 to 4, 10 to 8 and 11 to 14. `rxTrigHit` is 1 exactly when `rxCount` equals the selected threshold.
- R7: The receive queue keeps accepting bytes up to 16. A write to a full queue without a read in the same cycle is dropped, and `rxOverrun` is 1 for exactly the following cycle.
- R8: A transmit write to a full queue without a read in the same cycle is dropped. The count and the byte order are left unchanged.
- R9: A read from an empty queue changes neither the count nor the contents.
- R10: Each queue is first-in first-out. While the count is non-zero, the oldest byte is shown on `txDout` or `rxDout`, and a read removes it.
- R11: After reset both counts are 0, `txRdyN` is 0, `rxRdyN` is 1, `rxOverrun` is 0, and the per-character behaviour applies while the control byte is 0.
- R12: Bits 1, 2, 4 and 5 of `fifoCtrl` have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| fifoCtrl | input | 8 | Decoded queue control byte |
| txPush | input | 1 | Write strobe, transmit queue |
| txData | input | 8 | Byte to write into transmit queue |
| txPop | input | 1 | Read strobe from the transmit shifter |
| txDout | output | 8 | Oldest transmit byte |
| rxPush | input | 1 | Write strobe from the receive shifter |
| rxData | input | 8 | Received byte |
| rxPop | input | 1 | Read strobe, receive queue |
| rxDout | output | 8 | Oldest received byte |
| rxTimeout | input | 1 | Receive timeout pulse |
| txRdyN | output | 1 | Active-low transmit ready |
| rxRdyN | output | 1 | Active-low receive ready |
| rxTrigHit | output | 1 | Receive count equals threshold |
| rxOverrun | output | 1 | One-cycle dropped-byte pulse |
| txCount | output | 5 | Transmit occupancy |
| rxCount | output | 5 | Receive occupancy |

## Verification
Random traffic is run in fill-biased and drain-biased phases, so that both queues repeatedly pass through empty, threshold and full. Because of this, the hold of the block-transfer receive strobe can be told apart from a plain level comparison. The control byte is re-drawn in every phase with random unused bits, which covers every threshold code and both behaviours and separates the decoded bits from the ignored ones. Directed sequences add a timeout with a single byte queued, overflow on both queues, and reads from empty queues.

// File: rtl/uart_dma_pkg.sv
package uart_dma_pkg;

  // accepted queue operations, decided by control, applied by datapath
  typedef struct packed {
    logic txWr;
    logic txRd;
    logic rxWr;
    logic rxRd;
  } fifoStb_t;

  // receive threshold decode
  function automatic int unsigned rxTrigLevel(input logic [1:0] sel);
    case (sel)
      2'b00:   return 1;
      2'b01:   return 4;
      2'b10:   return 8;
      default: return 14;
    endcase
  endfunction

endpackage

// File: rtl/dma_fifo_store.sv
module dma_fifo_store #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8,
  parameter int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic [CNT_W-1:0]  count
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;

  always_ff @(posedge clk) begin
    if (wrEn) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (wrEn) wrPtr <= (wrPtr == LAST) ? '0 : wrPtr + 1'b1;
      if (rdEn) rdPtr <= (rdPtr == LAST) ? '0 : rdPtr + 1'b1;
      case ({wrEn, rdEn})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign rdData = mem[rdPtr];

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    count <= FULL); // R7

  AST_WRITE_GROWS: assert property (@(posedge clk) disable iff (!rstN)
    wrEn && !rdEn |=> count == $past(count) + 1'b1); // R10

  AST_READ_SHRINKS: assert property (@(posedge clk) disable iff (!rstN)
    rdEn && !wrEn |=> count == $past(count) - 1'b1); // R10

endmodule

// File: rtl/dma_fifo_datapath.sv
module dma_fifo_datapath
  import uart_dma_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8,
  parameter int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  fifoStb_t          stb,
  input  logic [DATA_W-1:0] txData,
  input  logic [DATA_W-1:0] rxData,
  output logic [DATA_W-1:0] txDout,
  output logic [DATA_W-1:0] rxDout,
  output logic [CNT_W-1:0]  txCount,
  output logic [CNT_W-1:0]  rxCount
);
  localparam int NCH = 2; // 0 = transmit, 1 = receive

  logic [NCH-1:0]    wrVec, rdVec;
  logic [DATA_W-1:0] inVec  [NCH];
  logic [DATA_W-1:0] outVec [NCH];
  logic [CNT_W-1:0]  cntVec [NCH];

  assign wrVec = {stb.rxWr, stb.txWr};
  assign rdVec = {stb.rxRd, stb.txRd};
  assign inVec[0] = txData;
  assign inVec[1] = rxData;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    dma_fifo_store #(
      .DEPTH (DEPTH),
      .DATA_W(DATA_W),
      .CNT_W (CNT_W)
    ) u_store (
      .clk   (clk),
      .rstN  (rstN),
      .wrEn  (wrVec[ch]),
      .rdEn  (rdVec[ch]),
      .wrData(inVec[ch]),
      .rdData(outVec[ch]),
      .count (cntVec[ch])
    );
  end

  assign txDout  = outVec[0];
  assign rxDout  = outVec[1];
  assign txCount = cntVec[0];
  assign rxCount = cntVec[1];

endmodule

// File: rtl/dma_ready_ctrl.sv
module dma_ready_ctrl
  import uart_dma_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [7:0]       fifoCtrl,
  input  logic             txPush,
  input  logic             txPop,
  input  logic             rxPush,
  input  logic             rxPop,
  input  logic             rxTimeout,
  input  logic [CNT_W-1:0] txCount,
  input  logic [CNT_W-1:0] rxCount,
  output fifoStb_t         stb,
  output logic             txRdyN,
  output logic             rxRdyN,
  output logic             rxTrigHit,
  output logic             rxOverrun
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  logic isMode1;
  logic txFull, txEmpty, rxFull, rxEmpty;
  logic [CNT_W-1:0] trigLvl, rxNext;
  logic rxArmed;

  assign isMode1 = fifoCtrl[0] & fifoCtrl[3];
  assign trigLvl = CNT_W'(rxTrigLevel(fifoCtrl[7:6]));

  assign txFull  = (txCount == FULL);
  assign txEmpty = (txCount == '0);
  assign rxFull  = (rxCount == FULL);
  assign rxEmpty = (rxCount == '0);

  // accept decisions: a read frees a slot for a same-cycle write
  always_comb begin
    stb.txRd = txPop & ~txEmpty;
    stb.txWr = txPush & (~txFull | stb.txRd);
    stb.rxRd = rxPop & ~rxEmpty;
    stb.rxWr = rxPush & (~rxFull | stb.rxRd);
  end

  assign rxNext = rxCount + CNT_W'(stb.rxWr) - CNT_W'(stb.rxRd);

  // block-transfer receive latch: set at threshold or timeout, cleared on drain
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxArmed   <= 1'b0;
      rxOverrun <= 1'b0;
    end else begin
      rxArmed   <= (rxNext != '0) &&
                   (rxArmed || (rxNext >= trigLvl) || rxTimeout);
      rxOverrun <= rxPush & ~stb.rxWr;
    end
  end

  always_comb begin
    if (isMode1) begin
      txRdyN = txFull;
      rxRdyN = ~rxArmed;
    end else begin
      txRdyN = ~txEmpty;
      rxRdyN = rxEmpty;
    end
  end

  assign rxTrigHit = (rxCount == trigLvl);

  AST_RX_HOLD_LOW: assert property (@(posedge clk) disable iff (!rstN)
    isMode1 && rxCount != '0 && $past(isMode1 && !rxRdyN) |-> !rxRdyN); // R5

  AST_RX_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    isMode1 && rxCount == '0 |-> rxRdyN); // R5

  AST_TX_FIRST_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    !isMode1 && $past(txCount == '0 && txPush) |-> txRdyN); // R2

  AST_OVERRUN_FULL: assert property (@(posedge clk) disable iff (!rstN)
    rxOverrun |-> $past(rxCount) == FULL); // R7

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    txFull && txPush && !txPop |=> txCount == FULL); // R8

  AST_EMPTY_POP: assert property (@(posedge clk) disable iff (!rstN)
    rxEmpty && rxPop && !rxPush |=> rxCount == '0); // R9

endmodule

// File: rtl/uart_fifo_dma_rdy.sv
module uart_fifo_dma_rdy
  import uart_dma_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8,
  parameter int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [7:0]        fifoCtrl,
  input  logic              txPush,
  input  logic [DATA_W-1:0] txData,
  input  logic              txPop,
  output logic [DATA_W-1:0] txDout,
  input  logic              rxPush,
  input  logic [DATA_W-1:0] rxData,
  input  logic              rxPop,
  output logic [DATA_W-1:0] rxDout,
  input  logic              rxTimeout,
  output logic              txRdyN,
  output logic              rxRdyN,
  output logic              rxTrigHit,
  output logic              rxOverrun,
  output logic [CNT_W-1:0]  txCount,
  output logic [CNT_W-1:0]  rxCount
);
  fifoStb_t stb;

  dma_ready_ctrl #(
    .DEPTH(DEPTH),
    .CNT_W(CNT_W)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .fifoCtrl (fifoCtrl),
    .txPush   (txPush),
    .txPop    (txPop),
    .rxPush   (rxPush),
    .rxPop    (rxPop),
    .rxTimeout(rxTimeout),
    .txCount  (txCount),
    .rxCount  (rxCount),
    .stb      (stb),
    .txRdyN   (txRdyN),
    .rxRdyN   (rxRdyN),
    .rxTrigHit(rxTrigHit),
    .rxOverrun(rxOverrun)
  );

  dma_fifo_datapath #(
    .DEPTH (DEPTH),
    .DATA_W(DATA_W),
    .CNT_W (CNT_W)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .stb    (stb),
    .txData (txData),
    .rxData (rxData),
    .txDout (txDout),
    .rxDout (rxDout),
    .txCount(txCount),
    .rxCount(rxCount)
  );

endmodule

// File: tb/uart_fifo_dma_rdy_tb.sv
module uart_fifo_dma_rdy_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] fifoCtrl = '0;
  logic txPush = 0, txPop = 0, rxPush = 0, rxPop = 0, rxTimeout = 0;
  logic [7:0] txData = '0, rxData = '0;
  logic [7:0] txDout, rxDout;
  logic txRdyN, rxRdyN, rxTrigHit, rxOverrun;
  logic [4:0] txCount, rxCount;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  logic [7:0] txQ[$];
  logic [7:0] rxQ[$];
  bit mArmed = 0;
  bit mOvr = 0;

  always #10 clk = ~clk; // 50 MHz

  uart_fifo_dma_rdy u_dut (
    .clk(clk), .rstN(rstN), .fifoCtrl(fifoCtrl),
    .txPush(txPush), .txData(txData), .txPop(txPop), .txDout(txDout),
    .rxPush(rxPush), .rxData(rxData), .rxPop(rxPop), .rxDout(rxDout),
    .rxTimeout(rxTimeout), .txRdyN(txRdyN), .rxRdyN(rxRdyN),
    .rxTrigHit(rxTrigHit), .rxOverrun(rxOverrun),
    .txCount(txCount), .rxCount(rxCount)
  );

  function automatic int trigOf(input logic [7:0] c);
    case (c[7:6])
      2'b00: return 1;
      2'b01: return 4;
      2'b10: return 8;
      default: return 14;
    endcase
  endfunction

  function automatic bit modeOne(input logic [7:0] c);
    return c[0] && c[3];
  endfunction

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic checkAll();
    int tc = txQ.size();
    int rc = rxQ.size();
    bit m1 = modeOne(fifoCtrl);
    check("R8/R9 txCount", int'(txCount), tc);
    check("R7/R9 rxCount", int'(rxCount), rc);
    check("R1/R2/R4/R12 txRdyN", int'(txRdyN), m1 ? int'(tc == 16) : int'(tc != 0));
    check("R1/R3/R5/R12 rxRdyN", int'(rxRdyN), m1 ? int'(!mArmed) : int'(rc == 0));
    check("R6 rxTrigHit", int'(rxTrigHit), int'(rc == trigOf(fifoCtrl)));
    check("R7 rxOverrun", int'(rxOverrun), int'(mOvr));
    if (tc > 0) check("R10 txDout", int'(txDout), int'(txQ[0]));
    if (rc > 0) check("R10 rxDout", int'(rxDout), int'(rxQ[0]));
  endtask

  // one clock of stimulus, model update, then check after the edge
  task automatic step(input logic [7:0] ctl, input bit tp, input bit tpo,
                      input bit rp, input bit rpo, input bit to);
    bit txRd, txWr, rxRd, rxWr;
    int n;
    @(negedge clk);
    fifoCtrl = ctl; txPush = tp; txPop = tpo; rxPush = rp; rxPop = rpo;
    rxTimeout = to;
    txData = 8'($urandom); rxData = 8'($urandom);
    txRd = tpo && txQ.size() > 0;
    txWr = tp && (txQ.size() < 16 || txRd);
    rxRd = rpo && rxQ.size() > 0;
    rxWr = rp && (rxQ.size() < 16 || rxRd);
    if (txRd) void'(txQ.pop_front());
    if (txWr) txQ.push_back(txData);
    if (rxRd) void'(rxQ.pop_front());
    if (rxWr) rxQ.push_back(rxData);
    n = rxQ.size();
    mArmed = (n != 0) && (mArmed || n >= trigOf(ctl) || to);
    mOvr = rp && !rxWr;
    @(posedge clk);
    #2;
    checkAll();
  endtask

  initial begin
    logic [7:0] ctl;
    void'($urandom(32'd4242));
    #15;
    check("R11 reset txRdyN", int'(txRdyN), 0);
    check("R11 reset rxRdyN", int'(rxRdyN), 1);
    check("R11 reset txCount", int'(txCount), 0);
    check("R11 reset rxCount", int'(rxCount), 0);
    check("R11 reset rxOverrun", int'(rxOverrun), 0);
    @(negedge clk); rstN = 1'b1;

    // R2: first byte into transmit queue in per-character behaviour
    step(8'h00, 1, 0, 0, 0, 0);
    check("R2 txRdyN after first load", int'(txRdyN), 1);
    step(8'h00, 0, 1, 0, 0, 0);
    check("R2 txRdyN after drain", int'(txRdyN), 0);

    // R9: reads from empty queues
    step(8'h09, 0, 1, 0, 1, 0);
    check("R9 empty pop rxCount", int'(rxCount), 0);

    // R5: threshold 4 in block-transfer behaviour, hold until drained
    for (int i = 0; i < 4; i++) step(8'h49, 0, 0, 1, 0, 0);
    check("R5 rxRdyN at threshold", int'(rxRdyN), 0);
    for (int i = 0; i < 3; i++) step(8'h49, 0, 0, 0, 1, 0);
    check("R5 rxRdyN held below threshold", int'(rxRdyN), 0);
    step(8'h49, 0, 0, 0, 1, 0);
    check("R5 rxRdyN released on drain", int'(rxRdyN), 1);

    // R5: timeout with one byte and threshold 8
    step(8'h89, 0, 0, 1, 0, 0);
    check("R5 rxRdyN before timeout", int'(rxRdyN), 1);
    step(8'h89, 0, 0, 0, 0, 1);
    check("R5 rxRdyN after timeout", int'(rxRdyN), 0);
    step(8'h89, 0, 0, 0, 1, 0);

    // R7: fill receive queue with threshold 14 then overflow
    for (int i = 0; i < 16; i++) step(8'hC9, 0, 0, 1, 0, 0);
    step(8'hC9, 0, 0, 1, 0, 0);
    check("R7 overrun pulse", int'(rxOverrun), 1);
    step(8'hC9, 0, 0, 0, 0, 0);
    check("R7 overrun one cycle", int'(rxOverrun), 0);

    // R4/R8: fill transmit queue in block-transfer behaviour, then overflow
    for (int i = 0; i < 16; i++) step(8'h09, 1, 0, 0, 0, 0);
    check("R4 txRdyN full", int'(txRdyN), 1);
    step(8'h09, 1, 0, 0, 0, 0);
    check("R8 txCount after dropped write", int'(txCount), 16);
    // R12: unused bits flipped, same outputs
    step(8'h3F, 0, 0, 0, 0, 0);
    check("R12 txRdyN unused bits", int'(txRdyN), 1);

    // random phases
    for (int ph = 0; ph < 24; ph++) begin
      int pPush = (ph % 2 == 0) ? 80 : 25;
      int pPop  = (ph % 2 == 0) ? 25 : 80;
      ctl = 8'($urandom);
      if ($urandom_range(1, 0) == 1) ctl = ctl | 8'h09;
      for (int k = 0; k < 120; k++) begin
        step(ctl,
             $urandom_range(99, 0) < pPush, $urandom_range(99, 0) < pPop,
             $urandom_range(99, 0) < pPush, $urandom_range(99, 0) < pPop,
             $urandom_range(99, 0) < 3);
      end
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog R11 actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

endmodule